// File: doc/BRIEF.md
# Unlock Command Sequence Detector

This block sits beside a battery-less shadowed memory and watches its bus for command cycles, which are writes made with the nonvolatile enable, chip enable and write enable strobes all held low. It recognises a three-step address/data unlock handshake. The last step's data byte picks one of three actions: request an immediate store of the RAM into the shadow array, turn on the automatic-save feature, or turn it off.

The block also owns the automatic-save trigger. When the feature is on and the low-supply flag rises, it issues exactly one store request and pulls its open-drain status line low for as long as the supply stays low. A power-on-reset flag turns the feature off. A very-low-supply inhibit flag blocks every command and every store. The strobes are sampled on the block clock. A command cycle counts once, on the clock where the three strobes first become low together.

Top module: `unlock_cmd_detector`

## Requirements
- R1: A command cycle is counted once, on the first clock on which `nv_en_n`, `chip_en_n` and `wr_en_n` are all sampled low. Holding the strobes low longer does not count again. If any of the three strobes is high, no cycle is counted.
- R2: The handshake runs in order: step one is address 0x555 with data 0xAA, then step two is address 0x2AA with data 0x55. A command cycle that does not match the expected step returns the detector to idle.
- R3: A mismatching command cycle that is itself address 0x555 with data 0xAA restarts the handshake, so the next expected step is step two.
- R4: A third step of address 0x555 with data 0x33 raises `store_req` for exactly one clock, in the clock after the third cycle is sampled.
- R5: A third step of address 0x555 with data 0xCC turns automatic save on, and one with data 0xCD turns it off. A third step with any other address or data causes no action and returns the detector to idle.
- R6: Writes made with `nv_en_n` high neither advance nor reset the handshake.
- R7: While automatic save is on, a rising low-supply flag produces exactly one `store_req` pulse. No further pulse is issued until `supply_low` has been seen low again.
- R8: `save_alert_n` is driven low (open-drain pull) while automatic save is on and `supply_low` is high. Otherwise it is released high. It lags its inputs by one clock.
- R9: `por_flag` turns automatic save off and returns the handshake to idle.
- R10: While `supply_inhibit` is high, command cycles are ignored and no `store_req` is issued.
- R11: After reset, `store_req` is 0, `save_alert_n` is 1 and automatic save is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_en_n | input | 1 | Nonvolatile enable strobe, active low |
| chip_en_n | input | 1 | Chip enable strobe, active low |
| wr_en_n | input | 1 | Write enable strobe, active low |
| addr | input | 11 | Bus address |
| data | input | 8 | Bus write data |
| supply_low | input | 1 | Supply below the save threshold |
| supply_inhibit | input | 1 | Supply too low for any operation |
| por_flag | input | 1 | Power-on reset indication |
| store_req | output | 1 | One-clock store request to the shadow array |
| save_alert_n | output | 1 | Active-low open-drain status: 0 pulls, 1 releases |

## Verification
The handshake is tried with the clean order for each of the three final bytes. Separate patterns cover a wrong step-two address, a wrong final byte and a wrong final address, which show whether mismatches really return to idle. A repeated first step distinguishes a restart from a reset. RAM writes and chip-enable-high writes placed between steps show that non-command traffic is transparent. A strobe held low for several clocks shows that a command counts once per strobe assertion. Supply sequences of low, still low, recovered and low again separate a one-shot save from a level-triggered one. Power-on reset and inhibit are each applied both in the middle of a handshake and with automatic save armed.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_HAVE1 = 2'd1,
        SEQ_HAVE2 = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_STORE  = 2'd1,
        ACT_ARM    = 2'd2,
        ACT_DISARM = 2'd3
    } act_e;

    typedef struct packed {
        logic strobe_prev;
    } samp_regs_t;

    typedef struct packed {
        seq_e st;
    } seq_regs_t;

    typedef struct packed {
        logic en;
        logic armed;
        logic auto_fire;
        logic store_req;
        logic alert_n;
    } save_regs_t;

endpackage

// File: rtl/cmd_strobe_sampler.sv
module cmd_strobe_sampler
    import unlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nv_en_n,
    input  logic chip_en_n,
    input  logic wr_en_n,
    output logic evt
);

    samp_regs_t r_q, r_d;
    logic       active;

    always_comb begin
        r_d             = r_q;
        active          = !nv_en_n && !chip_en_n && !wr_en_n;
        r_d.strobe_prev = active;
        evt             = active && !r_q.strobe_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt); // R1

endmodule

// File: rtl/unlock_seq_fsm.sv
module unlock_seq_fsm
    import unlock_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR_A = 11'h555,
    parameter logic [ADDR_W-1:0] KEY_ADDR_B = 11'h2AA,
    parameter logic [DATA_W-1:0] KEY_DATA_A = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_DATA_B = 8'h55,
    parameter logic [DATA_W-1:0] OP_STORE   = 8'h33,
    parameter logic [DATA_W-1:0] OP_ARM     = 8'hCC,
    parameter logic [DATA_W-1:0] OP_DISARM  = 8'hCD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              inhibit,
    input  logic              por,
    output act_e              act
);

    seq_regs_t r_q, r_d;
    logic      is_key1, is_key2, at_a;

    always_comb begin
        r_d     = r_q;
        act     = ACT_NONE;
        at_a    = (addr == KEY_ADDR_A);
        is_key1 = at_a && (data == KEY_DATA_A);
        is_key2 = (addr == KEY_ADDR_B) && (data == KEY_DATA_B);
        if (por) begin
            r_d.st = SEQ_IDLE;
        end else if (evt && !inhibit) begin
            unique case (r_q.st)
                SEQ_IDLE: begin
                    r_d.st = is_key1 ? SEQ_HAVE1 : SEQ_IDLE;
                end
                SEQ_HAVE1: begin
                    if (is_key2)      r_d.st = SEQ_HAVE2;
                    else if (is_key1) r_d.st = SEQ_HAVE1;
                    else              r_d.st = SEQ_IDLE;
                end
                SEQ_HAVE2: begin
                    r_d.st = is_key1 ? SEQ_HAVE1 : SEQ_IDLE;
                    if (at_a) begin
                        if (data == OP_STORE)       act = ACT_STORE;
                        else if (data == OP_ARM)    act = ACT_ARM;
                        else if (data == OP_DISARM) act = ACT_DISARM;
                    end
                end
                default: r_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: SEQ_IDLE};
        else        r_q <= r_d;
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SEQ_IDLE && !evt) |=> (r_q.st == SEQ_IDLE)); // R6
    AST_INHIBIT_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |-> (act == ACT_NONE)); // R10

endmodule

// File: rtl/autosave_ctl.sv
module autosave_ctl
    import unlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  act_e act,
    input  logic supply_low,
    input  logic inhibit,
    input  logic por,
    output logic store_req,
    output logic alert_n
);

    save_regs_t r_q, r_d;
    logic       fire, sw_store;

    always_comb begin
        r_d      = r_q;
        fire     = r_q.en && supply_low && r_q.armed && !inhibit;
        sw_store = (act == ACT_STORE) && !inhibit;

        if (por)                     r_d.en = 1'b0;
        else if (act == ACT_ARM)     r_d.en = 1'b1;
        else if (act == ACT_DISARM)  r_d.en = 1'b0;

        if (fire)             r_d.armed = 1'b0;
        else if (!supply_low) r_d.armed = 1'b1;

        r_d.auto_fire = fire;
        r_d.store_req = fire || sw_store;
        r_d.alert_n   = !(r_q.en && supply_low);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{en: 1'b0, armed: 1'b1, auto_fire: 1'b0,
                             store_req: 1'b0, alert_n: 1'b1};
        else        r_q <= r_d;
    end

    assign store_req = r_q.store_req;
    assign alert_n   = r_q.alert_n;

    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.auto_fire && supply_low) |=> !r_q.auto_fire); // R7
    AST_ALERT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !alert_n |-> $past(r_q.en)); // R8
    AST_INHIBIT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inhibit) |-> !store_req); // R10
    AST_POR_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(por) |-> !r_q.en); // R9

endmodule

// File: rtl/unlock_cmd_detector.sv
module unlock_cmd_detector
    import unlock_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_en_n,
    input  logic              chip_en_n,
    input  logic              wr_en_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic              supply_low,
    input  logic              supply_inhibit,
    input  logic              por_flag,
    output logic              store_req,
    output logic              save_alert_n
);

    logic evt;
    act_e act;

    cmd_strobe_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_en_n   (nv_en_n),
        .chip_en_n (chip_en_n),
        .wr_en_n   (wr_en_n),
        .evt       (evt)
    );

    unlock_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .addr    (addr),
        .data    (data),
        .inhibit (supply_inhibit),
        .por     (por_flag),
        .act     (act)
    );

    autosave_ctl u_save (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (act),
        .supply_low (supply_low),
        .inhibit    (supply_inhibit),
        .por        (por_flag),
        .store_req  (store_req),
        .alert_n    (save_alert_n)
    );

endmodule

// File: tb/unlock_cmd_detector_bench.sv
`timescale 1ns/1ps
module unlock_cmd_detector_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nv_en_n = 1'b1, chip_en_n = 1'b1, wr_en_n = 1'b1;
    logic [10:0] addr = '0;
    logic [7:0]  data = '0;
    logic        supply_low = 1'b0, supply_inhibit = 1'b0, por_flag = 1'b0;
    logic        store_req, save_alert_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    unlock_cmd_detector u_unlock_cmd_detector (
        .clk(clk), .rst_n(rst_n), .nv_en_n(nv_en_n), .chip_en_n(chip_en_n),
        .wr_en_n(wr_en_n), .addr(addr), .data(data), .supply_low(supply_low),
        .supply_inhibit(supply_inhibit), .por_flag(por_flag),
        .store_req(store_req), .save_alert_n(save_alert_n)
    );

    // {ne,ce,we}, addr, data, supply_low, expected store_req, expected save_alert_n
    localparam int NV = 38;
    localparam logic [24:0] VEC [0:NV-1] = '{
        {3'b000, 11'h555, 8'hAA, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h2AA, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'h33, 1'b0, 1'b1, 1'b1},
        {3'b000, 11'h555, 8'hAA, 1'b0, 1'b0, 1'b1},
        {3'b100, 11'h2AA, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h2AA, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'h33, 1'b0, 1'b1, 1'b1},
        {3'b000, 11'h555, 8'hAA, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h123, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h2AA, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'h33, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'hAA, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'hAA, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h2AA, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'h33, 1'b0, 1'b1, 1'b1},
        {3'b000, 11'h555, 8'hAA, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h2AA, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'hCC, 1'b0, 1'b0, 1'b1},
        {3'b111, 11'h000, 8'h00, 1'b1, 1'b1, 1'b0},
        {3'b111, 11'h000, 8'h00, 1'b1, 1'b0, 1'b0},
        {3'b111, 11'h000, 8'h00, 1'b0, 1'b0, 1'b1},
        {3'b111, 11'h000, 8'h00, 1'b1, 1'b1, 1'b0},
        {3'b111, 11'h000, 8'h00, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'hAA, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h2AA, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'hCD, 1'b0, 1'b0, 1'b1},
        {3'b111, 11'h000, 8'h00, 1'b1, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'hAA, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h2AA, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'h34, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'h33, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'hAA, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h2AA, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h554, 8'h33, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'hAA, 1'b0, 1'b0, 1'b1},
        {3'b010, 11'h2AA, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h2AA, 8'h55, 1'b0, 1'b0, 1'b1},
        {3'b000, 11'h555, 8'h33, 1'b0, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(input logic [2:0] s, input logic [10:0] a, input logic [7:0] d,
                        input logic low);
        {nv_en_n, chip_en_n, wr_en_n} = s;
        addr = a;
        data = d;
        supply_low = low;
        @(negedge clk);
    endtask

    task automatic idle(input logic low);
        step(3'b111, addr, data, low);
    endtask

    task automatic cmd(input logic [10:0] a, input logic [7:0] d);
        step(3'b000, a, d, supply_low);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 store_req after reset", store_req, 1'b0);
        check("R11 save_alert_n after reset", save_alert_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R2 R3 R4 R5 R6 R7 R8 and R1 (chip enable high)
        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            step(v[24:22], v[21:11], v[10:3], v[2]);
            check($sformatf("table vec %0d store_req", i), store_req, v[1]);
            check($sformatf("table vec %0d save_alert_n", i), save_alert_n, v[0]);
            idle(v[2]);
        end

        // R1: a held strobe counts once
        step(3'b000, 11'h555, 8'hAA, 1'b0);
        step(3'b000, 11'h555, 8'hAA, 1'b0);
        step(3'b000, 11'h555, 8'hAA, 1'b0);
        idle(1'b0);
        cmd(11'h2AA, 8'h55); idle(1'b0);
        cmd(11'h555, 8'h33);
        check("R1 held first step then store", store_req, 1'b1);
        // R4: held final strobe gives a single pulse
        cmd(11'h555, 8'h33);
        check("R4 store pulse one clock", store_req, 1'b0);
        idle(1'b0);

        // R9: por clears automatic save
        cmd(11'h555, 8'hAA); idle(1'b0);
        cmd(11'h2AA, 8'h55); idle(1'b0);
        cmd(11'h555, 8'hCC); idle(1'b0);
        por_flag = 1'b1; idle(1'b0); por_flag = 1'b0;
        idle(1'b1);
        check("R9 no save after por", store_req, 1'b0);
        idle(1'b1);
        check("R9 alert released after por", save_alert_n, 1'b1);
        idle(1'b0);
        // R9: por mid-handshake returns to idle
        cmd(11'h555, 8'hAA); idle(1'b0);
        cmd(11'h2AA, 8'h55); idle(1'b0);
        por_flag = 1'b1; idle(1'b0); por_flag = 1'b0;
        cmd(11'h555, 8'h33);
        check("R9 handshake dropped by por", store_req, 1'b0);
        idle(1'b0);

        // R10: inhibit blocks commands
        supply_inhibit = 1'b1;
        cmd(11'h555, 8'hAA); idle(1'b0);
        cmd(11'h2AA, 8'h55); idle(1'b0);
        cmd(11'h555, 8'h33);
        check("R10 inhibited software store", store_req, 1'b0);
        idle(1'b0);
        supply_inhibit = 1'b0;
        cmd(11'h555, 8'h33);
        check("R10 inhibited steps not counted", store_req, 1'b0);
        idle(1'b0);
        // R10: inhibit blocks the automatic save; R7 fires once it lifts
        cmd(11'h555, 8'hAA); idle(1'b0);
        cmd(11'h2AA, 8'h55); idle(1'b0);
        cmd(11'h555, 8'hCC); idle(1'b0);
        supply_inhibit = 1'b1;
        idle(1'b1);
        check("R10 inhibited auto save", store_req, 1'b0);
        check("R8 alert while enabled and low", save_alert_n, 1'b0);
        supply_inhibit = 1'b0;
        idle(1'b1);
        check("R7 auto save after inhibit lifts", store_req, 1'b1);
        idle(1'b1);
        check("R7 single pulse per event", store_req, 1'b0);
        idle(1'b0);
        idle(1'b0);
        check("R8 alert released on recovery", save_alert_n, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule